// File: doc/BRIEF.md
# Protected Register Write Sequencer

This block sits on a simple peripheral bus and shields a small set of critical registers from stray stores. Before a guarded register may be written, software stores a byte to a dedicated unlock (command) address. The byte's value does not matter. The store that comes right after it must go to one of the guarded addresses. That one store is passed through to the guarded register as a one-cycle write enable, together with its data and byte-lane mask. Any other ordering is refused and logged.

The unlock is single-use. The next peripheral store consumes it, whatever that store is. The block records misuse in a sticky error flag, which lives in a status register that software can read and clear. Misuse means either of two cases: a guarded write that was not unlocked, or a store after an unlock that misses every guarded address. A store to the status register itself, or a second unlock store, also counts as a miss. Reads never disturb the unlock.

Each bus cycle carries at most one operation: a store (`bus_wr`), a read (`bus_rd`) or nothing. A store carries a bit mask: all ones for a byte store, one bit set for a single-bit store. The guarded enables, the mirrored data and the error flag are all registered outputs.

Top module: `prot_wr_seq`

## Requirements
- R1: After synchronous reset, `prot_err` is 0, `prot_we` is all zero, `bus_rdata` is 0x00, and the block is locked.
- R2: A store to the unlock address with any data arms the block. The next store, to guarded address i, raises `prot_we[i]` for exactly one cycle, starting the cycle after that store. `prot_wdata` and `prot_wmask` show that store's data and mask, and the error flag is not set.
- R3: A store to a guarded address when the previous store was not to the unlock address leaves every `prot_we` bit low and sets `prot_err` to 1.
- R4: After an unlock, if the next store goes to any address that is not guarded, `prot_err` becomes 1 and no enable is raised.
- R5: Two unlock stores in a row set `prot_err`. The second one re-arms the block, so a guarded store right after it is accepted.
- R6: A store to the status register right after an unlock leaves `prot_err` at 1, even when it writes 0 to bit 4.
- R7: While the block is locked, a store to the status register clears the flag when its mask has bit 4 set and its data has bit 4 at 0. This holds for a byte store (mask 0xFF) and for a single-bit store (mask 0x10). A status store that writes 1 to bit 4, or whose mask leaves bit 4 out, leaves the flag unchanged.
- R8: A read of the status address returns, one cycle later, the error flag at bit 4 with all other bits 0. A read of the unlock address returns 0x00.
- R9: Reads neither consume nor cancel an unlock.
- R10: The unlock is consumed by the first following store. A second guarded store after a single unlock is blocked and sets `prot_err`.
- R11: Once set, `prot_err` stays 1 through every store other than a clearing status store made while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Peripheral address of the current operation |
| bus_wr | input | 1 | Store strobe, one cycle per store |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Store data |
| bus_wmask | input | 8 | Store bit mask (0xFF byte store, one-hot for a bit store) |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| prot_we | output | NPROT | One-cycle write enable per guarded register |
| prot_wdata | output | 8 | Data for the enabled guarded register |
| prot_wmask | output | 8 | Bit mask for the enabled guarded register |
| prot_err | output | 1 | Sticky protection-error flag (status bit 4) |

## Verification
Every result is registered once. The enable, the mirrored data and mask, and the error flag all change at the same clock edge that captures the store. Read data appears at the edge that captures the read. The bench drives each operation on a falling edge and checks the outputs just after the next rising edge. It drives the next operation on the falling edge straight after, so stores run back to back on consecutive cycles and the unlock state carries across them. A reference model built from the requirements is updated per operation. The bench sweeps all three-store sequences over nine store kinds and reads the status between sequences.

// File: rtl/prot_wr_pkg.sv
package prot_wr_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_BIT = 4;

  typedef struct packed {
    logic cmd;
    logic sts;
    logic prot_any;
  } dec_t;
endpackage

// File: rtl/prot_addr_dec.sv
module prot_addr_dec
  import prot_wr_pkg::*;
#(
  parameter int AW = 8,
  parameter int NPROT = 4,
  parameter logic [AW-1:0] CMD_ADDR = 8'h70,
  parameter logic [AW-1:0] STS_ADDR = 8'h78,
  parameter logic [NPROT*AW-1:0] PROT_ADDRS = 32'h13121110
) (
  input  logic [AW-1:0]    addr,
  output logic [NPROT-1:0] prot_hit,
  output dec_t             dec
);
  // One comparator per guarded address
  for (genvar i = 0; i < NPROT; i++) begin : g_cmp
    assign prot_hit[i] = (addr == PROT_ADDRS[i*AW +: AW]);
  end

  always_comb begin
    dec.cmd      = (addr == CMD_ADDR);
    dec.sts      = (addr == STS_ADDR);
    dec.prot_any = |prot_hit;
  end
endmodule

// File: rtl/prot_unlock.sv
module prot_unlock (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic cmd_hit,
  input  logic prot_any,
  output logic armed,
  output logic violation
);
  // A store breaks the rule when a guarded target meets a locked block,
  // or when an armed block sees a store to anything unguarded.
  always_comb begin
    violation = 1'b0;
    if (wr) begin
      if (armed) violation = !prot_any;
      else       violation = prot_any;
    end
  end

  // Every store consumes the unlock; an unlock store re-arms.
  always_ff @(posedge clk) begin
    if (rst)     armed <= 1'b0;
    else if (wr) armed <= cmd_hit;
  end

  p_arm_on_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && cmd_hit) |=> armed);
  p_consume_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && !cmd_hit) |=> !armed);
  p_read_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(armed));
endmodule

// File: rtl/prot_err_flag.sv
module prot_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic sts_hit,
  input  logic mask_bit,
  input  logic data_bit,
  input  logic violation,
  output logic err
);
  logic clr_req;
  assign clr_req = wr && sts_hit && mask_bit && !data_bit;

  // A violation wins over a clear made in the same store.
  always_ff @(posedge clk) begin
    if (rst)            err <= 1'b0;
    else if (violation) err <= 1'b1;
    else if (clr_req)   err <= 1'b0;
  end

  p_set_on_violation_r3: assert property (@(posedge clk) disable iff (rst)
    violation |=> err);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !violation) |=> !err);
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err && !clr_req) |=> err);
endmodule

// File: rtl/prot_wr_seq.sv
module prot_wr_seq
  import prot_wr_pkg::*;
#(
  parameter int AW = 8,
  parameter int NPROT = 4,
  parameter logic [AW-1:0] CMD_ADDR = 8'h70,
  parameter logic [AW-1:0] STS_ADDR = 8'h78,
  parameter logic [NPROT*AW-1:0] PROT_ADDRS = 32'h13121110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_wmask,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NPROT-1:0]  prot_we,
  output logic [DATA_W-1:0] prot_wdata,
  output logic [DATA_W-1:0] prot_wmask,
  output logic              prot_err
);
  logic [NPROT-1:0] prot_hit;
  dec_t             dec;
  logic             armed;
  logic             violation;

  prot_addr_dec #(
    .AW(AW), .NPROT(NPROT), .CMD_ADDR(CMD_ADDR),
    .STS_ADDR(STS_ADDR), .PROT_ADDRS(PROT_ADDRS)
  ) u_dec (
    .addr(bus_addr), .prot_hit(prot_hit), .dec(dec)
  );

  prot_unlock u_unlock (
    .clk(clk), .rst(rst), .wr(bus_wr), .cmd_hit(dec.cmd),
    .prot_any(dec.prot_any), .armed(armed), .violation(violation)
  );

  prot_err_flag u_err (
    .clk(clk), .rst(rst), .wr(bus_wr), .sts_hit(dec.sts),
    .mask_bit(bus_wmask[ERR_BIT]), .data_bit(bus_wdata[ERR_BIT]),
    .violation(violation), .err(prot_err)
  );

  // Guarded write path: enable only for an armed store.
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_we    <= '0;
      prot_wdata <= '0;
      prot_wmask <= '0;
    end else begin
      prot_we <= (bus_wr && armed) ? prot_hit : '0;
      if (bus_wr && armed && dec.prot_any) begin
        prot_wdata <= bus_wdata;
        prot_wmask <= bus_wmask;
      end
    end
  end

  // Read path: status shows the flag at its bit; everything else reads 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd && dec.sts) begin
      bus_rdata <= '0;
      bus_rdata[ERR_BIT] <= prot_err;
    end else begin
      bus_rdata <= '0;
    end
  end

  p_we_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prot_we));
  p_we_needs_unlock_r3: assert property (@(posedge clk) disable iff (rst)
    (prot_we != '0) |-> $past(armed && bus_wr));
  p_we_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> (prot_we == '0));
  p_sts_read_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && dec.sts) |=> (bus_rdata == (DATA_W'(prot_err) << ERR_BIT)));
endmodule

// File: tb/sim_prot_wr_seq.sv
module sim_prot_wr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NPROT = 4;
  localparam logic [7:0] CMD = 8'h70;
  localparam logic [7:0] STS = 8'h78;
  localparam logic [7:0] OTHER = 8'h20;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_wmask = '0;
  logic [7:0] bus_rdata, prot_wdata, prot_wmask;
  logic [NPROT-1:0] prot_we;
  logic prot_err;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic m_armed = 0, m_err = 0;

  prot_wr_seq u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .prot_we(prot_we), .prot_wdata(prot_wdata), .prot_wmask(prot_wmask),
    .prot_err(prot_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int prot_idx(input logic [7:0] a);
    if (a >= 8'h10 && a <= 8'h13) return int'(a - 8'h10);
    return -1;
  endfunction

  // One store; outputs checked just after the capturing edge.
  task automatic store(input logic [7:0] a, input logic [7:0] d, input logic [7:0] m,
                       input string req);
    int idx = prot_idx(a);
    logic viol;
    logic [NPROT-1:0] exp_we = '0;
    viol = m_armed ? (idx < 0) : (idx >= 0);
    if (m_armed && idx >= 0) exp_we[idx] = 1'b1;
    if (viol) m_err = 1'b1;
    else if (a == STS && m[4] && !d[4]) m_err = 1'b0;
    m_armed = (a == CMD);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1; bus_rd = 0;
    @(posedge clk); #1;
    chk({req, " we"}, 32'(prot_we), 32'(exp_we));
    chk({req, " err"}, 32'(prot_err), 32'(m_err));
    if (exp_we != '0) begin
      chk({req, " wdata"}, 32'(prot_wdata), 32'(d));
      chk({req, " wmask"}, 32'(prot_wmask), 32'(m));
    end
  endtask

  task automatic read(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_wr = 0; bus_rd = 1;
    @(posedge clk); #1;
    chk(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 err", 32'(prot_err), 0);
    chk("R1 we", 32'(prot_we), 0);
    chk("R1 rdata", 32'(bus_rdata), 0);
    store(8'h11, 8'hAA, 8'hFF, "R1 locked after reset");
    store(STS, 8'h00, 8'hFF, "R7 byte clear");
    // R2 each guarded register unlocked, also data ignored on cmd
    for (int i = 0; i < NPROT; i++) begin
      store(CMD, 8'(i * 37), 8'hFF, "R2 unlock");
      store(8'(8'h10 + i), 8'(8'h5A ^ i), 8'hFF, "R2 guarded write");
    end
    idle();
    @(posedge clk); #1;
    chk("R2 pulse one cycle", 32'(prot_we), 0);
    // R4 non-guarded store after unlock
    store(CMD, 8'h00, 8'hFF, "R4 unlock");
    store(OTHER, 8'h01, 8'hFF, "R4 miss");
    store(STS, 8'hEF, 8'h10, "R7 bit clear");
    // R6 status clear right after unlock
    store(CMD, 8'hFF, 8'hFF, "R6 unlock");
    store(STS, 8'h00, 8'hFF, "R6 clear refused");
    read(STS, 8'h10, "R8 status read set");
    read(CMD, 8'h00, "R8 cmd read");
    store(STS, 8'h00, 8'hFF, "R7 clear");
    read(STS, 8'h00, "R8 status read clear");
    // R5 double unlock
    store(CMD, 8'h01, 8'hFF, "R5 first");
    store(CMD, 8'h02, 8'hFF, "R5 second");
    store(8'h12, 8'h33, 8'h04, "R5 re-armed");
    // R7 writing 1, or mask without bit 4
    store(STS, 8'h10, 8'hFF, "R7 write one");
    store(STS, 8'h00, 8'hEF, "R7 mask off");
    store(STS, 8'h00, 8'hFF, "R7 clear");
    store(STS, 8'h10, 8'h10, "R7 write one clear state");
    // R9 reads in the middle of an unlock
    store(CMD, 8'h00, 8'hFF, "R9 unlock");
    read(STS, 8'h00, "R9 read status");
    read(8'h13, 8'h00, "R9 read guarded");
    store(8'h13, 8'h77, 8'hFF, "R9 still armed");
    // R10 single use
    store(CMD, 8'h00, 8'hFF, "R10 unlock");
    store(8'h10, 8'h01, 8'hFF, "R10 first");
    store(8'h11, 8'h02, 8'hFF, "R10 second blocked");
    // R11 sweep of all three-store sequences
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++)
        for (int c = 0; c < 9; c++) begin
          int ks[3];
          ks[0] = a; ks[1] = b; ks[2] = c;
          foreach (ks[j]) begin
            case (ks[j])
              0: store(CMD, 8'(a + b), 8'hFF, "R11 sweep cmd");
              1, 2, 3, 4: store(8'(8'h0F + ks[j]), 8'(c * 9), 8'hFF, "R11 sweep guarded");
              5: store(STS, 8'h00, 8'hFF, "R11 sweep byte clear");
              6: store(STS, 8'h10, 8'h10, "R11 sweep write one");
              7: store(OTHER, 8'h00, 8'hFF, "R11 sweep other");
              default: store(STS, 8'hEF, 8'h10, "R11 sweep bit clear");
            endcase
          end
          read(STS, {3'b000, m_err, 4'b0000}, "R8 sweep status");
        end
    idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule